// File: doc/BRIEF.md
# Serial shift clock wait controller

This block generates the shift clock of an internally clocked synchronous serial port. It shifts an 8-bit register out on SO and in from SI, and it pauses the transfer with a wait state. While the block waits, the shift clock is parked high and both the bit counter and the shift register are frozen. Software leaves the wait by writing the control register with the no-wait flag set. The block returns to the wait either on its own, when the condition chosen by a 2-bit wait-request field is reached, or at once, when software writes the no-wait flag as 0.

The shift clock comes from the system clock through a divider whose half-period is set on an input. A bit counter counts the rising edges of the shift clock from 0 up to 8 and then wraps to 0. The wait conditions are decoded from this counter. The counter is cleared by reset, by a clock-stop strobe, by a mode-change strobe and by every control write. Each automatic entry into the wait state is marked by a one-cycle done pulse.

Top module: `sck_wait_ctrl`

## Requirements
- R1: The bit counter (cnt_o) rises by one on each rising shift-clock edge, counting 0,1,...,8 and then returning to 0, so the value after the k-th rising edge since the last clear is k mod 9.
- R2: cnt_o reads 0 on the cycle after any of these: reset, a clk_stop pulse, a mode_i2c pulse, or any write to the control register (wr_addr = 0).
- R3: Reset puts the block in the wait state. In the wait state sck_o is 1 and neither cnt_o nor shreg_o changes, except through a data write or a counter clear.
- R4: A control write with wr_data[0] = 1 (no-wait) made during the wait starts the clock. The first falling edge comes half_div+1 cycles after the write edge, and every later half-period also lasts half_div+1 cycles. SO takes the current MSB on each falling edge, and the register shifts left, taking in SI, on each rising edge.
- R5: The wait-request field is wr_data[2:1] of the control write. 00 never stops. 01 stops on the 8th rising edge (cnt_o = 8). 10 stops on the 9th rising edge (cnt_o = 0). 11 stops on whichever of those two comes first.
- R6: A control write with wr_data[0] = 0 enters the wait state at once. sck_o is 1 from the next cycle, and no done pulse is given.
- R7: A no-wait control write made while the clock is already running leaves the shift-clock timing unchanged and clears cnt_o.
- R8: done_o is a single-cycle pulse, asserted in the same cycle that sck_o rises for the edge that meets the wait condition.
- R9: A write with wr_addr = 1 loads wr_data into the shift register, and the loaded value can be read on shreg_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the data register |
| wr_data | input | 8 | Write data. For a control write: [0] no-wait, [2:1] wait request |
| clk_stop | input | 1 | Clock-stop strobe; clears the bit counter |
| mode_i2c | input | 1 | Strobe for a switch to two-wire bus mode; clears the bit counter |
| half_div | input | DIV_W | Half-period of the shift clock, minus one, in system clocks |
| si_i | input | 1 | Serial data in |
| sck_o | output | 1 | Shift clock; high while waiting |
| so_o | output | 1 | Serial data out |
| done_o | output | 1 | One-cycle pulse on automatic wait entry |
| cnt_o | output | 4 | Bit counter value |
| shreg_o | output | 8 | Shift register contents |

## Verification
The bench goes after the counter wrap. A design that stops at 8 or counts to 9 gives the wrong cnt_o sequence in free-running mode and the wrong final count in mode 10. It forces a wait while the clock is low. A late force shows a low sck_o or a spurious done pulse, and a missing clear leaves cnt_o nonzero. It re-releases the wait while the clock is running. A design that restarts the divider stretches the measured half-period, and one that skips the clear keeps counting from the old value. Random transfers in all three stopping modes check the count of rising edges, the bit order on SO, the captured SI byte, and the edge spacing for several divider settings.

// File: rtl/sck_wait_pkg.sv
package sck_wait_pkg;
  localparam int WORD_W = 8;
  localparam int CNT_MAX = WORD_W;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {
    WRQ_NONE  = 2'b00,
    WRQ_AT8   = 2'b01,
    WRQ_AT9   = 2'b10,
    WRQ_BOTH  = 2'b11
  } wrq_e;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(CNT_MAX)) ? '0 : c + 1'b1;
  endfunction

  function automatic logic wait_hit(input wrq_e q, input logic [CNT_W-1:0] c_new,
                                    input logic wrapped);
    logic hit8;
    hit8 = (c_new == CNT_W'(CNT_MAX));
    case (q)
      WRQ_AT8:  return hit8;
      WRQ_AT9:  return wrapped;
      WRQ_BOTH: return hit8 | wrapped;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sck_div.sv
module sck_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [DIV_W-1:0] dcnt;
  logic             tick;

  assign tick    = run && (dcnt == half_div);
  assign fall_ev = tick & sck;
  assign rise_ev = tick & ~sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck  <= 1'b1;
      dcnt <= '0;
    end else if (!run) begin
      sck  <= 1'b1;
      dcnt <= '0;
    end else if (tick) begin
      sck  <= ~sck;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/bit_cnt.sv
module bit_cnt
  import sck_wait_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrapped
);
  assign cnt_nxt = cnt_step(cnt);
  assign wrapped = (cnt == CNT_W'(CNT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt_nxt;
  end
endmodule

// File: rtl/shift_reg.sv
module shift_reg
  import sck_wait_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              out_ev,
  input  logic              in_ev,
  input  logic              si,
  output logic              so,
  output logic [WORD_W-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      so <= 1'b1;
    end else begin
      if (load)       sr <= load_val;
      else if (in_ev) sr <= {sr[WORD_W-2:0], si};
      if (out_ev)     so <= sr[WORD_W-1];
    end
  end
endmodule

// File: rtl/sck_wait_ctrl.sv
module sck_wait_ctrl
  import sck_wait_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clk_stop,
  input  logic              mode_i2c,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              si_i,
  output logic              sck_o,
  output logic              so_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] shreg_o
);
  logic       ctrl_wr, data_wr, force_wr, cnt_clr;
  logic       waiting, run, fall_ev, rise_ev, wrapped, auto_hit;
  wrq_e       wrq_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign ctrl_wr  = wr_en & ~wr_addr;
  assign data_wr  = wr_en & wr_addr;
  assign force_wr = ctrl_wr & ~wr_data[0];
  assign cnt_clr  = ctrl_wr | clk_stop | mode_i2c;
  assign run      = ~waiting & ~force_wr;
  assign auto_hit = rise_ev & ~ctrl_wr & wait_hit(wrq_q, cnt_nxt, wrapped);

  sck_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
    .sck(sck_o), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  bit_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clr), .step(rise_ev),
    .cnt(cnt_o), .cnt_nxt(cnt_nxt), .wrapped(wrapped)
  );

  shift_reg u_sr (
    .clk(clk), .rst_n(rst_n), .load(data_wr), .load_val(wr_data),
    .out_ev(fall_ev), .in_ev(rise_ev), .si(si_i), .so(so_o), .sr(shreg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b1;
      wrq_q   <= WRQ_NONE;
      done_o  <= 1'b0;
    end else begin
      done_o <= auto_hit;
      if (ctrl_wr) begin
        waiting <= ~wr_data[0];
        wrq_q   <= wrq_e'(wr_data[2:1]);
      end else if (auto_hit) begin
        waiting <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sck_wait_chk.sv
module sck_wait_chk
  import sck_wait_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              waiting,
  input logic              sck,
  input logic [CNT_W-1:0]  cnt,
  input logic              done,
  input logic              force_wr,
  input logic              cnt_clr,
  input logic              data_wr,
  input logic [WORD_W-1:0] sr
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX)); // R1
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt == '0)); // R2
  AST_WAIT_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> sck); // R3
  AST_WAIT_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !cnt_clr) |=> $stable(cnt)); // R3
  AST_WAIT_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !data_wr) |=> $stable(sr)); // R3
  AST_FORCE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (waiting && sck && !done)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (waiting && sck)); // R8
endmodule

bind sck_wait_ctrl sck_wait_chk u_chk (
  .clk(clk), .rst_n(rst_n), .waiting(waiting), .sck(sck_o), .cnt(cnt_o),
  .done(done_o), .force_wr(force_wr), .cnt_clr(cnt_clr), .data_wr(data_wr),
  .sr(shreg_o)
);

// File: tb/test_sck_wait_ctrl.sv
`timescale 1ns/1ps
module test_sck_wait_ctrl;
  localparam int DIV_W = 4;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_addr = 0, clk_stop = 0, mode_i2c = 0, si_i = 0;
  logic [7:0] wr_data = 0;
  logic [DIV_W-1:0] half_div = 1;
  logic sck_o, so_o, done_o;
  logic [3:0] cnt_o;
  logic [7:0] shreg_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  sck_wait_ctrl #(.DIV_W(DIV_W)) i_sck_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_stop(clk_stop), .mode_i2c(mode_i2c), .half_div(half_div), .si_i(si_i),
    .sck_o(sck_o), .so_o(so_o), .done_o(done_o), .cnt_o(cnt_o), .shreg_o(shreg_o)
  );

  always #5 clk = ~clk;

  function automatic int exp_rises(input int mode);
    return (mode == 2) ? 9 : 8;
  endfunction
  function automatic int exp_cnt_after(input int k);
    return k % 9;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input bit addr, input logic [7:0] d);
    wr_en = 1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // wait for the next shift-clock edge; returns cycles taken
  task automatic next_edge(output int cyc);
    logic p;
    p = sck_o;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (sck_o == p && cyc < 100);
  endtask

  task automatic xfer(input int mode, input logic [7:0] tx, input logic [7:0] rx,
                      input int h);
    int rises, falls, cyc, exp_r;
    logic [7:0] so_bits;
    logic [7:0] exp_sr;
    logic [3:0] c0;
    bit bad_gap, got_done;
    half_div = DIV_W'(h);
    wr(1'b1, tx);
    chk(shreg_o == tx, "R9 load", shreg_o, tx);
    wr(1'b0, {5'd0, mode[1:0], 1'b1});
    rises = 0; falls = 0; so_bits = 0; bad_gap = 0; got_done = 0;
    exp_r = exp_rises(mode);
    while (!got_done && rises < 12) begin
      next_edge(cyc);
      if (cyc != h + 1) bad_gap = 1;
      if (sck_o == 0) begin
        si_i = (falls < 8) ? rx[7 - falls] : 1'b1;
        falls++;
      end else begin
        if (rises < 8) so_bits[7 - rises] = so_o;
        rises++;
        got_done = done_o;
      end
    end
    chk(!bad_gap, "R4 half period", bad_gap, 0);
    chk(rises == exp_r, "R5 rises to stop", rises, exp_r);
    chk(so_bits == tx, "R4 SO msb first", so_bits, tx);
    exp_sr = (mode == 2) ? {rx[6:0], 1'b1} : rx;
    chk(shreg_o == exp_sr, "R4 SI capture", shreg_o, exp_sr);
    chk(cnt_o == ((mode == 2) ? 4'd0 : 4'd8), "R5 stop count", cnt_o,
        (mode == 2) ? 0 : 8);
    c0 = cnt_o;
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    bad_gap = 0;
    for (int i = 0; i < 2 * h + 4; i++) begin
      if (!sck_o || cnt_o != c0 || shreg_o != exp_sr) bad_gap = 1;
      @(negedge clk);
    end
    chk(!bad_gap, "R3 parked", bad_gap, 0);
  endtask

  initial begin
    int cyc, k;
    bit bad;
    repeat (3) @(negedge clk);
    chk(sck_o == 1 && cnt_o == 0 && !done_o, "R3 reset state", {sck_o, cnt_o}, 16);
    rst_n = 1;
    @(negedge clk);
    // hold in wait without release
    repeat (10) @(negedge clk);
    chk(sck_o == 1 && cnt_o == 0, "R3 no release", sck_o, 1);

    // directed transfers in each stopping mode
    xfer(1, 8'hA5, 8'h3C, 1);
    xfer(2, 8'h81, 8'hC3, 2);
    xfer(3, 8'h7E, 8'h96, 3);

    // free-running count and wrap (mode 00)
    half_div = 1;
    wr(1'b0, 8'h01);
    bad = 0; k = 0;
    for (int i = 0; i < 40; i++) begin
      next_edge(cyc);
      if (sck_o) begin
        k++;
        if (cnt_o != exp_cnt_after(k)) bad = 1;
      end
    end
    chk(!bad, "R1 count and wrap", cnt_o, exp_cnt_after(k));

    // re-release while running: timing kept, counter cleared
    next_edge(cyc);
    wr(1'b0, 8'h01);
    chk(cnt_o == 0, "R7 re-release clears", cnt_o, 0);
    next_edge(cyc);
    chk(cyc + 1 == 2, "R7 timing unchanged", cyc + 1, 2);
    next_edge(cyc);
    chk(cyc == 2, "R7 next half period", cyc, 2);

    // clock-stop and mode strobes clear the counter
    next_edge(cyc);
    while (cnt_o == 0) next_edge(cyc);
    clk_stop = 1; @(negedge clk); clk_stop = 0;
    chk(cnt_o == 0, "R2 clk_stop clear", cnt_o, 0);
    next_edge(cyc);
    while (cnt_o == 0) next_edge(cyc);
    mode_i2c = 1; @(negedge clk); mode_i2c = 0;
    chk(cnt_o == 0, "R2 mode change clear", cnt_o, 0);

    // forced wait while sck is low
    next_edge(cyc);
    if (sck_o) next_edge(cyc);
    wr(1'b0, 8'h00);
    chk(sck_o == 1 && cnt_o == 0, "R6 forced wait", sck_o, 1);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (!sck_o || done_o) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R6 held no done", bad, 0);

    // random transfers
    void'($urandom(32'd12345));
    for (int n = 0; n < 12; n++)
      xfer(1 + ($urandom % 3), 8'($urandom), 8'($urandom), 1 + ($urandom % 3));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule